// File: doc/BRIEF.md
# Four-Phase Parallel Word Receiver

This block takes boot data from an external host over a parallel input bus. Transfers use a fully interlocked two-wire handshake. The host owns an active-low strobe that says the bus holds valid data. The block owns an acknowledge line: low means it is ready to take a value, and high means it is busy or has just finished reading. One complete handshake cycle moves one value across the bus. The handshake is asynchronous to the block's clock, so the strobe passes through a synchronizer before the control logic uses it.

The block has two widths. In full-width mode every handshake delivers one complete word. In byte mode only the low half of the bus is used: the first transfer supplies the low byte, the second supplies the high byte, and the word is only presented after the second transfer. Words leave through a valid/ready output. A word that the consumer has not yet taken stops the block from offering another handshake, so no data can be overwritten. Parsing the stream and recovering from timeouts are left to the logic around it.

Top module: `par_word_rx`

## Requirements
- R1: After reset `dev_ack` is 1 and `word_valid` is 0.
- R2: `dev_ack` goes low only when all three hold at the same clock edge: `enable` is 1, no word is pending (`word_valid` 0), and the synchronized strobe is released (high). While `enable` is 0, `dev_ack` stays 1.
- R3: A low `host_stb_n` first sampled at clock edge k makes `dev_ack` go high after edge k+SYNC_STAGES+1. The bus value at that edge is the value captured. `dev_ack` stays low until then.
- R4: Once `dev_ack` is high after a capture, it stays high until the host releases the strobe. If `host_stb_n` is first sampled high at edge m, and R2's conditions hold, `dev_ack` goes low after edge m+SYNC_STAGES+1.
- R5: In full-width mode (`mode_byte` = 0), `word_out` equals the whole captured bus and `word_valid` rises at the capture edge. Later bus changes do not alter it.
- R6: In byte mode (`mode_byte` = 1), the first capture holds a byte and raises no `word_valid`. The second capture presents `word_out` = {second byte, first byte}.
- R7: In byte mode, bits [15:8] of `host_data` are ignored at every capture.
- R8: While `word_valid` = 1 and `word_ready` = 0, `word_valid` and `word_out` hold. `word_valid` clears at the edge where both are 1.
- R9: While a word is pending, no new handshake is offered: `dev_ack` stays 1 and the held word is unchanged.
- R10: A full-width capture discards any half-assembled byte. The next byte-mode word again needs two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows the block to offer a new handshake |
| mode_byte | input | 1 | 1: two 8-bit transfers per word; 0: one full-width transfer |
| host_data | input | 16 | Parallel data bus from the host |
| host_stb_n | input | 1 | Host data-valid strobe, active low, asynchronous |
| word_ready | input | 1 | Consumer accepts the presented word |
| dev_ack | output | 1 | Handshake line to host: 0 ready, 1 busy/read complete |
| word_out | output | 16 | Assembled word |
| word_valid | output | 1 | `word_out` holds a word not yet taken |

## Verification
The strobe crosses SYNC_STAGES flops before the block acts on it. The acknowledge therefore rises SYNC_STAGES+1 edges after a falling strobe is first sampled, and falls SYNC_STAGES+1 edges after a released strobe is first sampled. The word appears in the same edge as the acknowledge rise. The bench drives inputs just after the falling clock edge. It counts falling edges from the stimulus and checks the level one edge before and at the edge where each result is due. A behavioural per-clock reference model also predicts the acknowledge, valid and word outputs, and these are compared at every falling edge, so each result is checked in its exact cycle and not merely eventually.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;
   // Handshake phases; acknowledge is high in BUSY and DONE.
   typedef enum logic [1:0] {
      PH_BUSY   = 2'd0,
      PH_READY  = 2'd1,
      PH_SETTLE = 2'd2,
      PH_DONE   = 2'd3
   } hs_phase_e;
endpackage

// File: rtl/pwrx_sync.sv
module pwrx_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwrx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrx_hs_fsm.sv
module pwrx_hs_fsm
   import pwrx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic stb_s,     // synchronized strobe, active low
   input  logic pending,   // a word waits for the consumer
   output logic ack,
   output logic cap
);
   hs_phase_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_BUSY:   if (enable && !pending && stb_s) phase_d = PH_READY;
         PH_READY:  if (!stb_s)                      phase_d = PH_SETTLE;
         PH_SETTLE:                                  phase_d = PH_DONE;
         PH_DONE:   if (stb_s)                       phase_d = PH_BUSY;
         default:                                    phase_d = PH_BUSY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_BUSY;
      else        phase_q <= phase_d;
   end

   assign ack = (phase_q == PH_BUSY) || (phase_q == PH_DONE);
   assign cap = (phase_q == PH_SETTLE);

   // R2: a ready indication needs enable, no pending word and a released strobe
   p_ack_fall_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> ($past(enable) && !$past(pending) && $past(stb_s)));

   // R3: capture happens only after the synchronized strobe was seen low
   p_capture_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> !$past(stb_s));

   // R4: read-complete is held while the host keeps the strobe low
   p_hold_until_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DONE && !stb_s) |=> ack);
endmodule

// File: rtl/pwrx_assemble.sv
module pwrx_assemble #(
   parameter int DATA_W       = 16,
   parameter bit BYTE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              mode_byte,
   input  logic [DATA_W-1:0] din,
   input  logic              take,
   output logic [DATA_W-1:0] word,
   output logic              valid
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] word_q;
   logic              valid_q;

   if (BYTE_MODE_EN) begin : g_byte
      logic [HALF_W-1:0] lo_q;
      logic              have_lo_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q    <= '0;
            valid_q   <= 1'b0;
            lo_q      <= '0;
            have_lo_q <= 1'b0;
         end else begin
            if (valid_q && take) valid_q <= 1'b0;
            if (cap) begin
               if (!mode_byte) begin
                  word_q    <= din;
                  valid_q   <= 1'b1;
                  have_lo_q <= 1'b0;          // R10: drop half word
               end else if (have_lo_q) begin
                  word_q    <= {din[HALF_W-1:0], lo_q};
                  valid_q   <= 1'b1;
                  have_lo_q <= 1'b0;
               end else begin
                  lo_q      <= din[HALF_W-1:0];
                  have_lo_q <= 1'b1;
               end
            end
         end
      end
   end else begin : g_full
      logic unused_mode;
      assign unused_mode = mode_byte;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
         end else begin
            if (valid_q && take) valid_q <= 1'b0;
            if (cap) begin
               word_q  <= din;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign word  = word_q;
   assign valid = valid_q;

   // R8: an untaken word holds its value
   p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !take) |=> (valid && $stable(word)));

   // R9: the handshake never captures over a pending word
   p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> !valid);
endmodule

// File: rtl/par_word_rx.sv
module par_word_rx #(
   parameter int DATA_W       = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit BYTE_MODE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              mode_byte,
   input  logic [DATA_W-1:0] host_data,
   input  logic              host_stb_n,
   input  logic              word_ready,
   output logic              dev_ack,
   output logic [DATA_W-1:0] word_out,
   output logic              word_valid
);
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("par_word_rx: DATA_W must be even and at least 2");
   end

   logic stb_s;
   logic cap;
   logic pending;

   pwrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (host_stb_n),
      .q     (stb_s)
   );

   pwrx_hs_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .stb_s   (stb_s),
      .pending (pending),
      .ack     (dev_ack),
      .cap     (cap)
   );

   pwrx_assemble #(.DATA_W(DATA_W), .BYTE_MODE_EN(BYTE_MODE_EN)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cap),
      .mode_byte (mode_byte),
      .din       (host_data),
      .take      (word_ready),
      .word      (word_out),
      .valid     (word_valid)
   );

   assign pending = word_valid;
endmodule

// File: tb/par_word_rx_test.sv
module par_word_rx_test;
   localparam int STG = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        mode_byte = 1'b0;
   logic [15:0] host_data = 16'h0000;
   logic        host_stb_n = 1'b1;
   logic        word_ready = 1'b0;
   logic        dev_ack;
   logic [15:0] word_out;
   logic        word_valid;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;

   always #5 clk = ~clk;

   par_word_rx #(.DATA_W(16), .SYNC_STAGES(STG), .BYTE_MODE_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode_byte(mode_byte),
      .host_data(host_data), .host_stb_n(host_stb_n), .word_ready(word_ready),
      .dev_ack(dev_ack), .word_out(word_out), .word_valid(word_valid)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit       m_sync[STG];
   int       m_step;          // 0 waiting-to-offer, 1 offered, 2 reading, 3 read done
   bit       m_valid;
   bit [15:0] m_word;
   bit [7:0] m_lo;
   bit       m_half;

   task automatic model_reset();
      for (int i = 0; i < STG; i++) m_sync[i] = 1'b1;
      m_step = 0; m_valid = 0; m_word = '0; m_lo = '0; m_half = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit seen, was_valid;
         seen = m_sync[STG-1];
         was_valid = m_valid;
         for (int i = STG-1; i > 0; i--) m_sync[i] = m_sync[i-1];
         m_sync[0] = host_stb_n;
         if (m_valid && word_ready) m_valid = 0;
         if (m_step == 0) begin
            if (enable && !was_valid && seen) m_step = 1;
         end else if (m_step == 1) begin
            if (!seen) m_step = 2;
         end else if (m_step == 2) begin
            m_step = 3;
            if (!mode_byte) begin
               m_word = host_data; m_valid = 1; m_half = 0;
            end else if (m_half) begin
               m_word = {host_data[7:0], m_lo}; m_valid = 1; m_half = 0;
            end else begin
               m_lo = host_data[7:0]; m_half = 1;
            end
         end else begin
            if (seen) m_step = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         bit exp_ack;
         exp_ack = (m_step == 0 || m_step == 3);
         chk(dev_ack == exp_ack, "R3 model ack", {15'd0, dev_ack}, {15'd0, exp_ack});
         chk(word_valid == m_valid, "R8 model valid", {15'd0, word_valid}, {15'd0, m_valid});
         if (m_valid)
            chk(word_out == m_word, "R5 model word", word_out, m_word);
      end
   end

   // ---------------- host and consumer tasks ----------------
   task automatic send(input logic [15:0] v);
      while (dev_ack) @(negedge clk);
      #1 host_data = v; host_stb_n = 1'b0;
      @(negedge clk);
      while (!dev_ack) @(negedge clk);
      #1 host_data = ~v; host_stb_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic take(input logic [15:0] exp, input string tag);
      while (!word_valid) @(negedge clk);
      chk(word_out == exp, tag, word_out, exp);
      #1 word_ready = 1'b1;
      @(negedge clk);
      #1 word_ready = 1'b0;
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(dev_ack == 1'b1, "R1 ack after reset", {15'd0, dev_ack}, 16'd1);
      chk(word_valid == 1'b0, "R1 valid after reset", {15'd0, word_valid}, 16'd0);
      #1 rst_n = 1'b1;
      cmp_en = 1'b1;

      // R2: disabled block never offers
      repeat (20) @(negedge clk);
      chk(dev_ack == 1'b1, "R2 ack while disabled", {15'd0, dev_ack}, 16'd1);
      #1 enable = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(dev_ack == 1'b0, "R2 ack after enable", {15'd0, dev_ack}, 16'd0);

      // R3 / R4: exact handshake timing, consumer always ready
      #1 word_ready = 1'b1; host_data = 16'hBEEF; host_stb_n = 1'b0;
      for (int n = 1; n <= STG + 2; n++) begin
         @(negedge clk);
         if (n == STG + 1) chk(dev_ack == 1'b0, "R3 ack before due", {15'd0, dev_ack}, 16'd0);
         if (n == STG + 2) begin
            chk(dev_ack == 1'b1, "R3 ack rise due", {15'd0, dev_ack}, 16'd1);
            chk(word_out == 16'hBEEF, "R5 captured word", word_out, 16'hBEEF);
         end
      end
      #1 host_data = 16'h0000;
      repeat (5) @(negedge clk);
      chk(dev_ack == 1'b1, "R4 ack held while strobe low", {15'd0, dev_ack}, 16'd1);
      #1 host_stb_n = 1'b1;
      for (int n = 1; n <= STG + 2; n++) begin
         @(negedge clk);
         if (n == STG + 1) chk(dev_ack == 1'b1, "R4 ack before due", {15'd0, dev_ack}, 16'd1);
         if (n == STG + 2) chk(dev_ack == 1'b0, "R4 ack fall due", {15'd0, dev_ack}, 16'd0);
      end
      #1 word_ready = 1'b0;

      // R5: several full-width words
      send(16'h1234); take(16'h1234, "R5 word 1234");
      send(16'h0000); take(16'h0000, "R5 word 0000");
      send(16'hFFFF); take(16'hFFFF, "R5 word FFFF");
      send(16'hA55A); take(16'hA55A, "R5 word A55A");

      // R8 / R9: backpressure holds word and blocks new handshake
      send(16'h6C3E);
      repeat (30) @(negedge clk);
      chk(dev_ack == 1'b1, "R9 no offer while pending", {15'd0, dev_ack}, 16'd1);
      chk(word_valid == 1'b1, "R8 valid held", {15'd0, word_valid}, 16'd1);
      chk(word_out == 16'h6C3E, "R8 word held", word_out, 16'h6C3E);
      take(16'h6C3E, "R9 pending word");

      // R6 / R7: byte mode, low byte first, upper lines ignored
      #1 mode_byte = 1'b1;
      send(16'hAB12);
      repeat (6) @(negedge clk);
      chk(word_valid == 1'b0, "R6 no word after first byte", {15'd0, word_valid}, 16'd0);
      send(16'hCD34);
      take(16'h3412, "R7 byte pair with upper garbage");
      send(16'h00F0); send(16'hFF0F); take(16'h0FF0, "R6 byte pair 0FF0");

      // R10: full-width capture drops a half word
      send(16'h7755);
      #1 mode_byte = 1'b0;
      send(16'h9ABC); take(16'h9ABC, "R10 full word after half");
      #1 mode_byte = 1'b1;
      send(16'h1177); send(16'h2288); take(16'h8877, "R10 fresh byte pair");

      repeat (10) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule